// File: doc/BRIEF.md
# Double-Buffered Polyphase Scaler Coefficient Store

This block keeps the polyphase filter coefficients that a video scaler's filter datapath consumes. Software loads them through a register-style write port. A tap-select write names a filter set (one of six luma, chroma or alpha, vertical or horizontal sets), a start phase, a start tap-pair index and the tap count of that set. Each later data write then carries one even and one odd coefficient, and the write address steps on its own through the tap pairs of a phase and then on to the next phase. Only the first half of the 64-phase filter, phases 0 to 32, is stored, since the rest mirrors it.

Storage is split into two banks. The filter datapath reads the current bank through a registered read port addressed by set, phase and pair. Loads always go to the other bank. Writing the complement of the current-bank status to the bank-select input asks for a swap. The swap happens at the next frame-start strobe, so a frame never mixes old and new coefficients.

Top module: `scl_coef_ram`

## Requirements
- R1: After reset `cur_bank` is 0 and every read returns zero on both halves.
- R2: Set codes 0 to 5 (0 luma vertical, 1 luma horizontal, 2 chroma vertical, 3 chroma horizontal, 4 alpha vertical, 5 alpha horizontal) address six independent sets. Reads of codes 6 and 7 return zero, and data writes that follow a tap-select naming code 6 or 7 store nothing.
- R3: Phases 0 to 32 are stored. A read of phase 33 or above returns zero, and a tap-select start phase above 32 starts at phase 0.
- R4: A tap-select write sets the start pair and phase. Each data write stores at the pointer and then moves to the next pair. After pair (taps+1)/2-1 it moves to pair 0 of the next phase. Tap counts run 1 to 8.
- R5: A data write at the last pair of phase 32 moves the pointer to pair 0 of phase 0.
- R6: When the tap count is odd, the odd half of the last pair of each phase is stored as zero, whatever the data and the odd enable.
- R7: `tdata_even_en` and `tdata_odd_en` gate the storing of their halves separately. A half whose enable is low keeps its old value, and the pointer still advances.
- R8: Bits 1:0 of every coefficient read back as zero, whatever was written.
- R9: Tap-select and data writes go only to the bank that is not current. Reads of the current bank do not change while the other bank is loaded.
- R10: A bank-select write of a value different from `cur_bank` requests a swap. `cur_bank` flips at the next `frame_start` with a request pending, and at no other time.
- R11: A bank-select write equal to `cur_bank` cancels a pending swap request.
- R12: A read of pair index at or above (taps+1)/2 of the set's last tap-select returns zero. Read data appears one clock after the read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tsel_wr | input | 1 | Tap-select write strobe |
| tsel_pair | input | 2 | Start tap-pair index |
| tsel_phase | input | 6 | Start phase |
| tsel_type | input | 3 | Filter set code |
| tsel_taps | input | 4 | Tap count of the set, 1 to 8 |
| tdata_wr | input | 1 | Data write strobe |
| tdata_even | input | 14 | Even coefficient |
| tdata_even_en | input | 1 | Store the even half |
| tdata_odd | input | 14 | Odd coefficient |
| tdata_odd_en | input | 1 | Store the odd half |
| bsel_wr | input | 1 | Bank-select write strobe |
| bsel_val | input | 1 | Requested current bank |
| frame_start | input | 1 | Frame-start strobe that applies a pending swap |
| cur_bank | output | 1 | Current bank status |
| rd_type | input | 3 | Read set code |
| rd_phase | input | 6 | Read phase |
| rd_pair | input | 2 | Read tap-pair index |
| rd_even | output | 14 | Even coefficient of the addressed pair |
| rd_odd | output | 14 | Odd coefficient of the addressed pair |

## Verification
The bench fills sets with 8, 5 and 4 taps and sweeps every phase and pair after each swap. This catches a pointer that steps phases at the wrong pair count, or that fails to zero the last odd half for odd tap counts. It loads phase 32 and keeps writing, so a pointer that runs past the stored half shows up as a wrong value at phase 0 or 1. It also requests a swap, cancels it and strobes frames with and without a request, which exposes a bank that flips early, flips without frame start or ignores a cancel. Partial writes with a single half enabled, and writes after an invalid set code, check that nothing outside the enabled half is stored.

// File: rtl/scl_coef_pkg.sv
package scl_coef_pkg;

  typedef enum logic [2:0] {
    FSET_LUMA_V   = 3'd0,
    FSET_LUMA_H   = 3'd1,
    FSET_CHROMA_V = 3'd2,
    FSET_CHROMA_H = 3'd3,
    FSET_ALPHA_V  = 3'd4,
    FSET_ALPHA_H  = 3'd5
  } fset_e;

  // tap count clamped to the legal range 1..max_taps
  function automatic int clamp_taps(input int taps, input int max_taps);
    if (taps < 1) return 1;
    if (taps > max_taps) return max_taps;
    return taps;
  endfunction

  // tap pairs written per phase
  function automatic int pairs_for_taps(input int taps, input int max_taps);
    return (clamp_taps(taps, max_taps) + 1) / 2;
  endfunction

  function automatic logic taps_odd(input int taps, input int max_taps);
    return (clamp_taps(taps, max_taps) % 2) == 1;
  endfunction

  // flat slot of a coefficient pair: bank, set, phase, pair
  function automatic int slot_index(input int bank, input int fset, input int phase,
                                    input int pair, input int nsets, input int nph,
                                    input int npairs);
    return ((bank * nsets + fset) * nph + phase) * npairs + pair;
  endfunction

endpackage

// File: rtl/scl_coef_wr_seq.sv
module scl_coef_wr_seq
  import scl_coef_pkg::*;
#(
  parameter int NUM_SETS  = 6,
  parameter int STORED_PH = 33,
  parameter int MAX_TAPS  = 8,
  parameter int SET_W     = 3,
  parameter int PH_W      = 6,
  parameter int PAIR_W    = 2,
  parameter int TAPS_W    = 4,
  parameter int CNT_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic [PAIR_W-1:0] sel_pair,
  input  logic [PH_W-1:0]   sel_phase,
  input  logic [SET_W-1:0]  sel_type,
  input  logic [TAPS_W-1:0] sel_taps,
  input  logic              data_wr,
  output logic              wr_fire,
  output logic              wr_force_odd_zero,
  output logic              wr_wrap,
  output logic [SET_W-1:0]  wr_type,
  output logic [PH_W-1:0]   wr_phase,
  output logic [PAIR_W-1:0] wr_pair,
  output logic              set_load,
  output logic [CNT_W-1:0]  set_pairs
);

  logic              p_valid;
  logic              p_odd;
  logic [CNT_W-1:0]  p_np;
  logic [SET_W-1:0]  p_type;
  logic [PH_W-1:0]   p_phase;
  logic [PAIR_W-1:0] p_pair;

  logic sel_type_ok;
  logic sel_odd;
  logic last_pair;
  logic last_phase;
  logic [PH_W-1:0] start_phase;

  always_comb begin
    sel_type_ok = int'(sel_type) < NUM_SETS;
    set_pairs   = CNT_W'(pairs_for_taps(int'(sel_taps), MAX_TAPS));
    sel_odd     = taps_odd(int'(sel_taps), MAX_TAPS);
    start_phase = (int'(sel_phase) >= STORED_PH) ? '0 : sel_phase;
    set_load    = sel_wr && sel_type_ok;
  end

  always_comb begin
    last_pair         = (int'(p_pair) + 1) >= int'(p_np);
    last_phase        = int'(p_phase) == (STORED_PH - 1);
    wr_fire           = data_wr && !sel_wr && p_valid;
    wr_force_odd_zero = p_odd && (int'(p_pair) == int'(p_np) - 1);
    wr_wrap           = wr_fire && last_pair && last_phase;
    wr_type           = p_type;
    wr_phase          = p_phase;
    wr_pair           = p_pair;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_valid <= 1'b0;
      p_odd   <= 1'b0;
      p_np    <= '0;
      p_type  <= '0;
      p_phase <= '0;
      p_pair  <= '0;
    end else if (sel_wr) begin
      p_valid <= sel_type_ok;
      p_odd   <= sel_odd;
      p_np    <= set_pairs;
      p_type  <= sel_type;
      p_phase <= start_phase;
      p_pair  <= sel_pair;
    end else if (wr_fire) begin
      if (last_pair) begin
        p_pair  <= '0;
        p_phase <= last_phase ? '0 : PH_W'(int'(p_phase) + 1);
      end else begin
        p_pair <= PAIR_W'(int'(p_pair) + 1);
      end
    end
  end

endmodule

// File: rtl/scl_coef_bank_ctrl.sv
module scl_coef_bank_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic bsel_wr,
  input  logic bsel_val,
  input  logic frame_start,
  output logic cur_bank,
  output logic swap_pending,
  output logic swap_now
);

  logic req_now;
  logic cancel_now;

  always_comb begin
    req_now    = bsel_wr && (bsel_val != cur_bank);
    cancel_now = bsel_wr && (bsel_val == cur_bank);
    swap_now   = frame_start && (swap_pending || req_now);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_bank     <= 1'b0;
      swap_pending <= 1'b0;
    end else begin
      if (swap_now) cur_bank <= ~cur_bank;
      if (swap_now)        swap_pending <= 1'b0;
      else if (req_now)    swap_pending <= 1'b1;
      else if (cancel_now) swap_pending <= 1'b0;
    end
  end

endmodule

// File: rtl/scl_coef_store.sv
module scl_coef_store
  import scl_coef_pkg::*;
#(
  parameter int NUM_SETS  = 6,
  parameter int STORED_PH = 33,
  parameter int MAX_PAIRS = 4,
  parameter int COEF_W    = 14,
  parameter int SET_W     = 3,
  parameter int PH_W      = 6,
  parameter int PAIR_W    = 2,
  parameter int CNT_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              wr_bank,
  input  logic [SET_W-1:0]  wr_type,
  input  logic [PH_W-1:0]   wr_phase,
  input  logic [PAIR_W-1:0] wr_pair,
  input  logic              wr_even_en,
  input  logic [COEF_W-1:0] wr_even,
  input  logic              wr_odd_en,
  input  logic [COEF_W-1:0] wr_odd,
  input  logic              cnt_load,
  input  logic              cnt_bank,
  input  logic [SET_W-1:0]  cnt_type,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              rd_bank,
  input  logic [SET_W-1:0]  rd_type,
  input  logic [PH_W-1:0]   rd_phase,
  input  logic [PAIR_W-1:0] rd_pair,
  output logic [COEF_W-1:0] rd_even,
  output logic [COEF_W-1:0] rd_odd
);

  localparam int KEEP_W = COEF_W - 2;
  localparam int DEPTH  = 2 * NUM_SETS * STORED_PH * MAX_PAIRS;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int NSLOT  = 2 * NUM_SETS;

  logic [KEEP_W-1:0] mem_even [DEPTH];
  logic [KEEP_W-1:0] mem_odd  [DEPTH];
  logic [CNT_W-1:0]  set_cnt  [NSLOT];

  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [CNT_W-1:0] rd_cnt;
  logic             rd_type_ok;
  logic             rd_ok;

  // pair count of each bank/set, latched by tap-select writes
  for (genvar s = 0; s < NSLOT; s++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        set_cnt[s] <= '0;
      end else if (cnt_load &&
                   (int'(cnt_bank) * NUM_SETS + int'(cnt_type)) == s) begin
        set_cnt[s] <= cnt_val;
      end
    end
  end

  always_comb begin
    wr_idx = IDX_W'(slot_index(int'(wr_bank), int'(wr_type), int'(wr_phase),
                               int'(wr_pair), NUM_SETS, STORED_PH, MAX_PAIRS));
  end

  always_ff @(posedge clk) begin
    if (wr_fire && wr_even_en) mem_even[wr_idx] <= wr_even[COEF_W-1:2];
    if (wr_fire && wr_odd_en)  mem_odd[wr_idx]  <= wr_odd[COEF_W-1:2];
  end

  always_comb begin
    rd_type_ok = int'(rd_type) < NUM_SETS;
    rd_cnt     = rd_type_ok ? set_cnt[int'(rd_bank) * NUM_SETS + int'(rd_type)] : '0;
    rd_ok      = rd_type_ok && (int'(rd_phase) < STORED_PH) &&
                 (int'(rd_pair) < int'(rd_cnt));
    rd_idx     = rd_ok ? IDX_W'(slot_index(int'(rd_bank), int'(rd_type), int'(rd_phase),
                                           int'(rd_pair), NUM_SETS, STORED_PH,
                                           MAX_PAIRS))
                       : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_even <= '0;
      rd_odd  <= '0;
    end else if (rd_ok) begin
      rd_even <= {mem_even[rd_idx], 2'b00};
      rd_odd  <= {mem_odd[rd_idx], 2'b00};
    end else begin
      rd_even <= '0;
      rd_odd  <= '0;
    end
  end

endmodule

// File: rtl/scl_coef_ram.sv
module scl_coef_ram
  import scl_coef_pkg::*;
#(
  parameter int NUM_SETS = 6,
  parameter int PHASES   = 64,
  parameter int MAX_TAPS = 8,
  parameter int COEF_W   = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tsel_wr,
  input  logic [1:0]  tsel_pair,
  input  logic [5:0]  tsel_phase,
  input  logic [2:0]  tsel_type,
  input  logic [3:0]  tsel_taps,
  input  logic        tdata_wr,
  input  logic [13:0] tdata_even,
  input  logic        tdata_even_en,
  input  logic [13:0] tdata_odd,
  input  logic        tdata_odd_en,
  input  logic        bsel_wr,
  input  logic        bsel_val,
  input  logic        frame_start,
  output logic        cur_bank,
  input  logic [2:0]  rd_type,
  input  logic [5:0]  rd_phase,
  input  logic [1:0]  rd_pair,
  output logic [13:0] rd_even,
  output logic [13:0] rd_odd
);

  localparam int STORED_PH = PHASES / 2 + 1;
  localparam int MAX_PAIRS = (MAX_TAPS + 1) / 2;
  localparam int SET_W     = 3;
  localparam int PH_W      = $clog2(STORED_PH);
  localparam int PAIR_W    = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1;
  localparam int TAPS_W    = $clog2(MAX_TAPS + 1);
  localparam int CNT_W     = $clog2(MAX_PAIRS + 1);

  // internal events, named for the checker
  logic              wr_fire;
  logic              wr_force_odd_zero;
  logic              wr_wrap;
  logic [SET_W-1:0]  wr_type;
  logic [PH_W-1:0]   seq_phase;
  logic [PAIR_W-1:0] seq_pair;
  logic              set_load;
  logic [CNT_W-1:0]  set_pairs;
  logic              swap_pending;
  logic              swap_now;
  logic              shadow_bank;
  logic              odd_en_eff;
  logic [COEF_W-1:0] odd_val_eff;

  scl_coef_wr_seq #(
    .NUM_SETS (NUM_SETS),
    .STORED_PH(STORED_PH),
    .MAX_TAPS (MAX_TAPS),
    .SET_W    (SET_W),
    .PH_W     (PH_W),
    .PAIR_W   (PAIR_W),
    .TAPS_W   (TAPS_W),
    .CNT_W    (CNT_W)
  ) seq_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .sel_wr           (tsel_wr),
    .sel_pair         (tsel_pair),
    .sel_phase        (tsel_phase),
    .sel_type         (tsel_type),
    .sel_taps         (tsel_taps),
    .data_wr          (tdata_wr),
    .wr_fire          (wr_fire),
    .wr_force_odd_zero(wr_force_odd_zero),
    .wr_wrap          (wr_wrap),
    .wr_type          (wr_type),
    .wr_phase         (seq_phase),
    .wr_pair          (seq_pair),
    .set_load         (set_load),
    .set_pairs        (set_pairs)
  );

  scl_coef_bank_ctrl bank_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bsel_wr     (bsel_wr),
    .bsel_val    (bsel_val),
    .frame_start (frame_start),
    .cur_bank    (cur_bank),
    .swap_pending(swap_pending),
    .swap_now    (swap_now)
  );

  always_comb begin
    shadow_bank = ~cur_bank;
    odd_en_eff  = wr_force_odd_zero ? 1'b1 : tdata_odd_en;
    odd_val_eff = wr_force_odd_zero ? '0 : tdata_odd;
  end

  scl_coef_store #(
    .NUM_SETS (NUM_SETS),
    .STORED_PH(STORED_PH),
    .MAX_PAIRS(MAX_PAIRS),
    .COEF_W   (COEF_W),
    .SET_W    (SET_W),
    .PH_W     (PH_W),
    .PAIR_W   (PAIR_W),
    .CNT_W    (CNT_W)
  ) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (wr_fire),
    .wr_bank   (shadow_bank),
    .wr_type   (wr_type),
    .wr_phase  (seq_phase),
    .wr_pair   (seq_pair),
    .wr_even_en(tdata_even_en),
    .wr_even   (tdata_even),
    .wr_odd_en (odd_en_eff),
    .wr_odd    (odd_val_eff),
    .cnt_load  (set_load),
    .cnt_bank  (shadow_bank),
    .cnt_type  (tsel_type),
    .cnt_val   (set_pairs),
    .rd_bank   (cur_bank),
    .rd_type   (rd_type),
    .rd_phase  (rd_phase),
    .rd_pair   (rd_pair),
    .rd_even   (rd_even),
    .rd_odd    (rd_odd)
  );

endmodule

// File: rtl/scl_coef_ram_chk.sv
module scl_coef_ram_chk #(
  parameter int NUM_SETS  = 6,
  parameter int STORED_PH = 33
) (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_start,
  input logic        bsel_wr,
  input logic        bsel_val,
  input logic        cur_bank,
  input logic        swap_pending,
  input logic        wr_wrap,
  input logic [5:0]  seq_phase,
  input logic [1:0]  seq_pair,
  input logic [2:0]  rd_type,
  input logic [5:0]  rd_phase,
  input logic [13:0] rd_even,
  input logic [13:0] rd_odd
);

  a_r10_swap_only_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_bank != $past(cur_bank)) |-> $past(frame_start));

  a_r10_no_swap_without_request: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !swap_pending && !(bsel_wr && bsel_val != cur_bank))
      |=> $stable(cur_bank));

  a_r11_cancel_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bsel_wr && bsel_val == cur_bank && !frame_start) |=> !swap_pending);

  a_r5_pointer_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wrap |=> (seq_phase == 6'd0 && seq_pair == 2'd0));

  a_r8_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_even[1:0] == 2'b00 && rd_odd[1:0] == 2'b00));

  a_r2_bad_set_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_type) >= NUM_SETS) |=> (rd_even == '0 && rd_odd == '0));

  a_r3_bad_phase_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_phase) >= STORED_PH) |=> (rd_even == '0 && rd_odd == '0));

endmodule

bind scl_coef_ram scl_coef_ram_chk #(
  .NUM_SETS (NUM_SETS),
  .STORED_PH(STORED_PH)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .bsel_wr     (bsel_wr),
  .bsel_val    (bsel_val),
  .cur_bank    (cur_bank),
  .swap_pending(swap_pending),
  .wr_wrap     (wr_wrap),
  .seq_phase   (seq_phase),
  .seq_pair    (seq_pair),
  .rd_type     (rd_type),
  .rd_phase    (rd_phase),
  .rd_even     (rd_even),
  .rd_odd      (rd_odd)
);

// File: tb/scl_coef_ram_tb_top.sv
module scl_coef_ram_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tsel_wr = 1'b0;
  logic [1:0]  tsel_pair = '0;
  logic [5:0]  tsel_phase = '0;
  logic [2:0]  tsel_type = '0;
  logic [3:0]  tsel_taps = '0;
  logic        tdata_wr = 1'b0;
  logic [13:0] tdata_even = '0;
  logic        tdata_even_en = 1'b0;
  logic [13:0] tdata_odd = '0;
  logic        tdata_odd_en = 1'b0;
  logic        bsel_wr = 1'b0;
  logic        bsel_val = 1'b0;
  logic        frame_start = 1'b0;
  logic        cur_bank;
  logic [2:0]  rd_type = '0;
  logic [5:0]  rd_phase = '0;
  logic [1:0]  rd_pair = '0;
  logic [13:0] rd_even;
  logic [13:0] rd_odd;

  always #5 clk = ~clk;

  scl_coef_ram dut_i (
    .clk(clk), .rst_n(rst_n),
    .tsel_wr(tsel_wr), .tsel_pair(tsel_pair), .tsel_phase(tsel_phase),
    .tsel_type(tsel_type), .tsel_taps(tsel_taps),
    .tdata_wr(tdata_wr), .tdata_even(tdata_even), .tdata_even_en(tdata_even_en),
    .tdata_odd(tdata_odd), .tdata_odd_en(tdata_odd_en),
    .bsel_wr(bsel_wr), .bsel_val(bsel_val), .frame_start(frame_start),
    .cur_bank(cur_bank),
    .rd_type(rd_type), .rd_phase(rd_phase), .rd_pair(rd_pair),
    .rd_even(rd_even), .rd_odd(rd_odd)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model of the stored state, kept from the requirements
  int me [2][6][33][4];
  int mo [2][6][33][4];
  int mcnt [2][6];
  int mcur = 0;
  int mpend = 0;
  int mvalid = 0;
  int mtype = 0, mph = 0, mpr = 0, mnp = 0, modd = 0;

  function automatic int pat(input int k);
    return (k * 1237 + 91) % 16384;
  endfunction

  function automatic int exp_val(input int t, input int ph, input int pr, input bit odd);
    if (t > 5 || ph > 32) return 0;
    if (pr >= mcnt[mcur][t]) return 0;
    return odd ? mo[mcur][t][ph][pr] : me[mcur][t][ph][pr];
  endfunction

  task automatic tsel(input int t, input int ph, input int pr, input int taps);
    int ct;
    @(negedge clk);
    tsel_wr = 1'b1; tsel_type = t[2:0]; tsel_phase = ph[5:0];
    tsel_pair = pr[1:0]; tsel_taps = taps[3:0];
    @(posedge clk); #1; tsel_wr = 1'b0;
    ct = (taps < 1) ? 1 : ((taps > 8) ? 8 : taps);
    if (t <= 5) begin
      mvalid = 1; mtype = t; mph = (ph > 32) ? 0 : ph; mpr = pr;
      mnp = (ct + 1) / 2; modd = ct % 2;
      mcnt[1 - mcur][t] = mnp;
    end else begin
      mvalid = 0;
    end
  endtask

  task automatic tdat(input int e, input bit ee, input int o, input bit oe);
    int b;
    @(negedge clk);
    tdata_wr = 1'b1; tdata_even = e[13:0]; tdata_even_en = ee;
    tdata_odd = o[13:0]; tdata_odd_en = oe;
    @(posedge clk); #1; tdata_wr = 1'b0;
    if (mvalid == 1) begin
      b = 1 - mcur;
      if (ee) me[b][mtype][mph][mpr] = e & 16'h3FFC;
      if (modd == 1 && mpr == mnp - 1) mo[b][mtype][mph][mpr] = 0;
      else if (oe) mo[b][mtype][mph][mpr] = o & 16'h3FFC;
      if (mpr + 1 >= mnp) begin
        mpr = 0; mph = (mph == 32) ? 0 : mph + 1;
      end else begin
        mpr = mpr + 1;
      end
    end
  endtask

  task automatic bsel(input int v);
    @(negedge clk);
    bsel_wr = 1'b1; bsel_val = v[0];
    @(posedge clk); #1; bsel_wr = 1'b0;
    mpend = (v != mcur) ? 1 : 0;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(posedge clk); #1; frame_start = 1'b0;
    if (mpend == 1) begin mcur = 1 - mcur; mpend = 0; end
  endtask

  task automatic load_set(input int t, input int taps, input int seed);
    int np;
    np = ((taps < 1 ? 1 : taps) + 1) / 2;
    tsel(t, 0, 0, taps);
    for (int ph = 0; ph < 33; ph++)
      for (int pr = 0; pr < np; pr++)
        tdat(pat(seed + ph * 8 + pr * 2), 1'b1, pat(seed + ph * 8 + pr * 2 + 1), 1'b1);
  endtask

  task automatic rd_chk(input int t, input int ph, input int pr, input string tag);
    int ee, eo;
    @(negedge clk);
    rd_type = t[2:0]; rd_phase = ph[5:0]; rd_pair = pr[1:0];
    @(negedge clk);
    ee = exp_val(t, ph, pr, 1'b0);
    eo = exp_val(t, ph, pr, 1'b1);
    checks++;
    if (rd_even !== ee[13:0] || rd_odd !== eo[13:0]) begin
      failures++;
      $display("FAIL %s set=%0d ph=%0d pair=%0d actual=%h/%h expected=%h/%h",
               tag, t, ph, pr, rd_even, rd_odd, ee[13:0], eo[13:0]);
    end
  endtask

  task automatic chk_set(input int t, input string tag);
    for (int ph = 0; ph < 33; ph++)
      for (int pr = 0; pr < 4; pr++)
        rd_chk(t, ph, pr, tag);
  endtask

  task automatic chk_cur(input string tag);
    @(negedge clk);
    checks++;
    if (cur_bank !== mcur[0]) begin
      failures++;
      $display("FAIL %s cur_bank actual=%0d expected=%0d", tag, cur_bank, mcur);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int t = 0; t < 6; t++) begin
        mcnt[b][t] = 0;
        for (int ph = 0; ph < 33; ph++)
          for (int pr = 0; pr < 4; pr++) begin
            me[b][t][ph][pr] = 0; mo[b][t][ph][pr] = 0;
          end
      end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    chk_cur("R1");
    rd_chk(0, 0, 0, "R1");
    rd_chk(5, 32, 3, "R1");

    // R4/R6: load two sets into the shadow bank (bank 1)
    load_set(1, 8, 10);
    load_set(2, 5, 500);
    // R9: current bank unaffected by loading
    rd_chk(1, 0, 0, "R9");
    rd_chk(2, 7, 1, "R9");

    // R10: request swap; no flip until frame start
    bsel(1);
    repeat (3) @(negedge clk);
    chk_cur("R10");
    frame();
    chk_cur("R10");

    chk_set(1, "R4");
    chk_set(2, "R6");        // odd last half zero, pair 3 unused -> R12
    rd_chk(2, 4, 3, "R12");
    rd_chk(6, 0, 0, "R2");
    rd_chk(7, 3, 1, "R2");
    rd_chk(1, 33, 0, "R3");
    rd_chk(1, 63, 2, "R3");

    // R7: per-half enables into bank 0, then writes after an invalid set code
    load_set(3, 4, 900);
    tsel(3, 5, 0, 4);
    tdat(14'h1ABF, 1'b1, 14'h0555, 1'b0);
    tdat(14'h2222, 1'b0, 14'h3FFF, 1'b1);
    tsel(7, 0, 0, 8);
    tdat(14'h3333, 1'b1, 14'h3333, 1'b1);
    tdat(14'h1111, 1'b1, 14'h1111, 1'b1);
    // R3: out-of-range start phase begins at phase 0
    tsel(4, 40, 0, 2);
    tdat(14'h0ACE, 1'b1, 14'h0BCD, 1'b1);
    bsel(0);
    frame();
    chk_cur("R10");
    chk_set(3, "R7");
    rd_chk(3, 5, 0, "R7");
    rd_chk(3, 5, 1, "R7");
    rd_chk(4, 0, 0, "R3");
    rd_chk(6, 5, 0, "R2");

    // R5: pointer wraps after the last pair of phase 32 (bank 1)
    tsel(0, 32, 0, 2);
    tdat(14'h1357, 1'b1, 14'h2468, 1'b1);
    tdat(14'h0F0F, 1'b1, 14'h3C3C, 1'b1);
    tdat(14'h2BAD, 1'b1, 14'h1DEA, 1'b1);
    bsel(1);
    frame();
    chk_cur("R10");
    rd_chk(0, 32, 0, "R5");
    rd_chk(0, 0, 0, "R5");
    rd_chk(0, 1, 0, "R5");
    rd_chk(0, 1, 1, "R12");
    // R9: bank 1 sets survived the bank-0 loads
    chk_set(1, "R9");
    chk_set(2, "R9");

    // R11: request then cancel; frame start leaves bank as is
    bsel(0);
    bsel(1);
    frame();
    chk_cur("R11");
    frame();
    chk_cur("R10");
    rd_chk(1, 16, 2, "R8");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule